// File: doc/BRIEF.md
# Prefetch Burst Data Serializer

This block sits between a memory core that moves one wide word per clock and a narrow double-data-rate pin bus. On the read side it accepts a core word four beats wide. It sends those beats out two per clock, on a rise lane and a fall lane. A data strobe goes with the beats: it is high for the rise beat and low for the fall beat, so it changes level at every beat boundary and its edges line up with the data. The strobe is replicated once per byte lane. Before the first beat the strobe is driven low for one full clock as a preamble. After the last beat it is driven low for one more half clock as a postamble.

On the write side it receives beat pairs that were already captured on both strobe edges. It packs each group of four beats into one core word and raises a single-cycle valid with it.

Each burst is 4 or 8 beats long. A burst of 8 uses two consecutive core words. Within each four-beat group, beats are placed by a starting column offset. The order is either sequential wrap or interleaved, chosen per command. A burst of 8 may be cut short by a new command in the same direction, but only at its midpoint. The new burst takes the place of the beats that were still to come.

Top module: `bser_top`

## Requirements
- R1: After synchronous reset: no beat is valid, all strobe drivers are off, both command-ready outputs are high, and no write word is valid.
- R2: A read command accepted while no read data is on the pins gives one preamble clock on the next cycle. In that clock both strobe half-enables are high, the strobe is low in both halves, and the valid flags are low.
- R3: After the preamble, a read burst of 4 gives two data clocks from the command's word. A burst of 8 gives four data clocks: the first two from the command's word, the next two from the word presented one cycle after the command.
- R4: In data clock p of a core word, the rise lane carries beat slot s(2·(p mod 2)) and the fall lane carries slot s(2·(p mod 2)+1). Here s(k) = (k + col) mod 4 when sequential (ilv=0) and s(k) = k xor col when interleaved (ilv=1). Slot j occupies bits [j·BEAT_W +: BEAT_W] of the core word.
- R5: In every data clock both valid flags are high, the strobe is high in the rise half and low in the fall half. Whenever the valid flags are low, both data lanes are zero.
- R6: The clock after the last data beat is a postamble: the rise-half enable is high with the strobe low, and the fall-half enable is low. The clock after that is idle, with all enables low.
- R7: The read ready output is high only when idle, in the postamble, or in the second data clock of a burst of 8. A read command presented while ready is low has no effect.
- R8: A read command accepted in the second data clock of a burst of 8 puts its own first beats on the pins in the very next clock, with no preamble. The old burst's remaining beats are dropped.
- R9: Write pairs are placed into the core word by the slot rule of R4, using the low two column bits. Each word is output with a one-cycle valid, one clock after its second pair. Its select bit is col[2] xor (1 for the second word of a burst of 8).
- R10: Write ready is high when no write burst is open, or after the first word of a burst of 8 has been gathered. A write command accepted then drops the old burst's remaining beats. A write command presented while ready is low has no effect.
- R11: A write pair presented while no write burst is open, or in the cycle a write command is accepted, is discarded.
- R12: All strobe outputs of the byte lanes carry identical values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read burst request |
| rd_bl8 | input | 1 | Read burst of 8 when high, 4 when low |
| rd_col | input | 2 | Read starting slot within each four-beat group |
| rd_ilv | input | 1 | Read order: 1 interleaved, 0 sequential |
| rd_word | input | 4·LANES·LANE_W | Core word (with command, and one cycle later for burst of 8) |
| rd_ready | output | 1 | Read command can be taken this cycle |
| dq_rise | output | LANES·LANE_W | Beat for the rising clock half |
| dq_fall | output | LANES·LANE_W | Beat for the falling clock half |
| dq_valid_rise | output | 1 | Rise lane beat valid |
| dq_valid_fall | output | 1 | Fall lane beat valid |
| dqs_rise | output | LANES | Strobe level per byte lane, rising half |
| dqs_fall | output | LANES | Strobe level per byte lane, falling half |
| dqs_oe_rise | output | LANES | Strobe drive enable per lane, rising half |
| dqs_oe_fall | output | LANES | Strobe drive enable per lane, falling half |
| wr_cmd | input | 1 | Write burst request |
| wr_bl8 | input | 1 | Write burst of 8 when high, 4 when low |
| wr_col | input | 3 | Write starting column; bits 1:0 slot, bit 2 word select |
| wr_ilv | input | 1 | Write order: 1 interleaved, 0 sequential |
| wr_pair_valid | input | 1 | A captured beat pair is present |
| wr_rise | input | LANES·LANE_W | Beat captured on the rising strobe edge |
| wr_fall | input | LANES·LANE_W | Beat captured on the falling strobe edge |
| wr_ready | output | 1 | Write command can be taken this cycle |
| wr_word | output | 4·LANES·LANE_W | Gathered core word |
| wr_word_valid | output | 1 | Gathered word valid (one cycle) |
| wr_word_sel | output | 1 | Which four-beat group of the burst this word holds |

## Verification
Suppose the read pair counter or the state register goes wrong. The pins then show the wrong beat slot, or a data clock too many or too few, in the same clock. A wrong preamble or postamble shows up one clock after the command, or right after the last beat. If the second-word capture or the word swap is wrong, that is visible in the third data clock of a burst of 8, and a bad interrupt point shows in the clock after the new command. On the write side, a miscounted pair or a stale accumulator corrupts the word or its select bit. It also shifts the valid pulse, which is seen one clock after the second pair of the affected group.

// File: rtl/bser_pkg.sv
package bser_pkg;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_PRE,
        RD_DATA,
        RD_POST
    } rd_state_e;

    typedef struct packed {
        logic [1:0] col;
        logic       ilv;
        logic       bl8;
    } rd_cfg_t;

    typedef struct packed {
        logic [2:0] col;
        logic       ilv;
        logic       bl8;
    } wr_cfg_t;

    typedef struct packed {
        logic vld;
        logic stb_r;
        logic stb_f;
        logic oe_r;
        logic oe_f;
    } pin_ctl_t;

    // Slot of beat k within a four-beat group for a given start offset.
    function automatic logic [1:0] beat_slot(input logic [1:0] k,
                                             input logic [1:0] c,
                                             input logic       ilv);
        return ilv ? (k ^ c) : (k + c);
    endfunction

endpackage

// File: rtl/bser_rd.sv
module bser_rd
    import bser_pkg::*;
#(
    parameter int BEAT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd,
    input  logic                  bl8,
    input  logic [1:0]            col,
    input  logic                  ilv,
    input  logic [4*BEAT_W-1:0]   word,
    output logic                  ready,
    output logic [BEAT_W-1:0]     rise,
    output logic [BEAT_W-1:0]     fall,
    output pin_ctl_t              ctl
);
    localparam int WORD_W = 4 * BEAT_W;

    rd_state_e         st;
    rd_cfg_t           cfg;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] nxt_word;
    logic [1:0]        pidx;
    logic              fetch2;
    logic              accept;
    logic              last_pair;
    logic              in_data;
    logic [1:0]        slot_r;
    logic [1:0]        slot_f;

    assign ready     = (st == RD_IDLE) || (st == RD_POST) ||
                       ((st == RD_DATA) && cfg.bl8 && (pidx == 2'd1));
    assign accept    = cmd && ready;
    assign last_pair = (pidx == (cfg.bl8 ? 2'd3 : 2'd1));
    assign in_data   = (st == RD_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RD_IDLE;
            cfg      <= '0;
            cur_word <= '0;
            nxt_word <= '0;
            pidx     <= 2'd0;
            fetch2   <= 1'b0;
        end else begin
            if (fetch2) begin
                nxt_word <= word;
            end
            fetch2 <= accept && bl8;
            if (accept) begin
                cur_word <= word;
                cfg      <= '{col: col, ilv: ilv, bl8: bl8};
                pidx     <= 2'd0;
                st       <= (st == RD_DATA) ? RD_DATA : RD_PRE;
            end else begin
                unique case (st)
                    RD_PRE: begin
                        st   <= RD_DATA;
                        pidx <= 2'd0;
                    end
                    RD_DATA: begin
                        if (last_pair) begin
                            st <= RD_POST;
                        end else begin
                            pidx <= pidx + 2'd1;
                            if (pidx == 2'd1) begin
                                cur_word <= nxt_word;
                            end
                        end
                    end
                    RD_POST: st <= RD_IDLE;
                    default: st <= RD_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        slot_r = beat_slot({pidx[0], 1'b0}, cfg.col, cfg.ilv);
        slot_f = beat_slot({pidx[0], 1'b1}, cfg.col, cfg.ilv);
        rise   = in_data ? cur_word[BEAT_W*int'(slot_r) +: BEAT_W] : '0;
        fall   = in_data ? cur_word[BEAT_W*int'(slot_f) +: BEAT_W] : '0;
        ctl.vld   = in_data;
        ctl.stb_r = in_data;
        ctl.stb_f = 1'b0;
        ctl.oe_r  = (st != RD_IDLE);
        ctl.oe_f  = (st == RD_PRE) || in_data;
    end

endmodule

// File: rtl/bser_wr.sv
module bser_wr
    import bser_pkg::*;
#(
    parameter int BEAT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd,
    input  logic                  bl8,
    input  logic [2:0]            col,
    input  logic                  ilv,
    input  logic                  pair_vld,
    input  logic [BEAT_W-1:0]     pin_rise,
    input  logic [BEAT_W-1:0]     pin_fall,
    output logic                  ready,
    output logic [4*BEAT_W-1:0]   word,
    output logic                  word_vld,
    output logic                  word_sel
);
    localparam int WORD_W = 4 * BEAT_W;

    logic              active;
    wr_cfg_t           cfg;
    logic [1:0]        cnt;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] asm_word;
    logic [1:0]        slot_r;
    logic [1:0]        slot_f;
    logic              accept;
    logic              take;
    logic              last_pair;

    assign ready     = !active || (cfg.bl8 && (cnt == 2'd2));
    assign accept    = cmd && ready;
    assign take      = active && pair_vld && !accept;
    assign last_pair = (cnt == (cfg.bl8 ? 2'd3 : 2'd1));

    always_comb begin
        slot_r   = beat_slot({cnt[0], 1'b0}, cfg.col[1:0], cfg.ilv);
        slot_f   = beat_slot({cnt[0], 1'b1}, cfg.col[1:0], cfg.ilv);
        asm_word = cnt[0] ? acc : '0;
        asm_word[BEAT_W*int'(slot_r) +: BEAT_W] = pin_rise;
        asm_word[BEAT_W*int'(slot_f) +: BEAT_W] = pin_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cfg      <= '0;
            cnt      <= 2'd0;
            acc      <= '0;
            word     <= '0;
            word_vld <= 1'b0;
            word_sel <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (accept) begin
                active <= 1'b1;
                cfg    <= '{col: col, ilv: ilv, bl8: bl8};
                cnt    <= 2'd0;
            end else if (take) begin
                if (!cnt[0]) begin
                    acc <= asm_word;
                end else begin
                    word     <= asm_word;
                    word_vld <= 1'b1;
                    word_sel <= cfg.col[2] ^ (cnt[1] & cfg.bl8);
                end
                if (last_pair) begin
                    active <= 1'b0;
                end else begin
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/bser_top.sv
module bser_top
    import bser_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_cmd,
    input  logic                        rd_bl8,
    input  logic [1:0]                  rd_col,
    input  logic                        rd_ilv,
    input  logic [4*LANES*LANE_W-1:0]   rd_word,
    output logic                        rd_ready,
    output logic [LANES*LANE_W-1:0]     dq_rise,
    output logic [LANES*LANE_W-1:0]     dq_fall,
    output logic                        dq_valid_rise,
    output logic                        dq_valid_fall,
    output logic [LANES-1:0]            dqs_rise,
    output logic [LANES-1:0]            dqs_fall,
    output logic [LANES-1:0]            dqs_oe_rise,
    output logic [LANES-1:0]            dqs_oe_fall,
    input  logic                        wr_cmd,
    input  logic                        wr_bl8,
    input  logic [2:0]                  wr_col,
    input  logic                        wr_ilv,
    input  logic                        wr_pair_valid,
    input  logic [LANES*LANE_W-1:0]     wr_rise,
    input  logic [LANES*LANE_W-1:0]     wr_fall,
    output logic                        wr_ready,
    output logic [4*LANES*LANE_W-1:0]   wr_word,
    output logic                        wr_word_valid,
    output logic                        wr_word_sel
);
    localparam int BEAT_W = LANES * LANE_W;

    pin_ctl_t rd_ctl;

    bser_rd #(.BEAT_W(BEAT_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .cmd   (rd_cmd),
        .bl8   (rd_bl8),
        .col   (rd_col),
        .ilv   (rd_ilv),
        .word  (rd_word),
        .ready (rd_ready),
        .rise  (dq_rise),
        .fall  (dq_fall),
        .ctl   (rd_ctl)
    );

    assign dq_valid_rise = rd_ctl.vld;
    assign dq_valid_fall = rd_ctl.vld;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dqs_rise[g]    = rd_ctl.stb_r;
        assign dqs_fall[g]    = rd_ctl.stb_f;
        assign dqs_oe_rise[g] = rd_ctl.oe_r;
        assign dqs_oe_fall[g] = rd_ctl.oe_f;
    end

    bser_wr #(.BEAT_W(BEAT_W)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (wr_cmd),
        .bl8      (wr_bl8),
        .col      (wr_col),
        .ilv      (wr_ilv),
        .pair_vld (wr_pair_valid),
        .pin_rise (wr_rise),
        .pin_fall (wr_fall),
        .ready    (wr_ready),
        .word     (wr_word),
        .word_vld (wr_word_valid),
        .word_sel (wr_word_sel)
    );

endmodule

// File: rtl/bser_chk.sv
module bser_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_cmd,
    input logic                     rd_ready,
    input logic [LANES*LANE_W-1:0]  dq_rise,
    input logic [LANES*LANE_W-1:0]  dq_fall,
    input logic                     dq_valid_rise,
    input logic                     dq_valid_fall,
    input logic [LANES-1:0]         dqs_rise,
    input logic [LANES-1:0]         dqs_fall,
    input logic [LANES-1:0]         dqs_oe_rise,
    input logic [LANES-1:0]         dqs_oe_fall,
    input logic                     wr_ready,
    input logic                     wr_word_valid
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rd_ready && wr_ready && !dq_valid_rise && !wr_word_valid
                 && dqs_oe_rise == '0 && dqs_oe_fall == '0));

    a_r2_preamble: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && rd_ready && !dq_valid_rise) |=>
        (dqs_oe_rise[0] && dqs_oe_fall[0] && !dqs_rise[0] && !dqs_fall[0]
         && !dq_valid_rise));

    a_r5_strobe_edge: assert property (@(posedge clk) disable iff (rst)
        dq_valid_rise |-> (dq_valid_fall && dqs_rise[0] && !dqs_fall[0]
                           && dqs_oe_rise[0] && dqs_oe_fall[0]));

    a_r5_quiet_lanes: assert property (@(posedge clk) disable iff (rst)
        !dq_valid_rise |-> (dq_rise == '0 && dq_fall == '0 && !dq_valid_fall));

    a_r6_postamble: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_valid_rise) |-> (dqs_oe_rise[0] && !dqs_oe_fall[0] && !dqs_rise[0]));

    a_r7_busy_preamble: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe_fall[0] && !dq_valid_rise) |-> !rd_ready);

    a_r8_seamless: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd && rd_ready && dq_valid_rise) |=> dq_valid_rise);

    a_r9_word_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_word_valid |=> !wr_word_valid);

    a_r12_lanes_match: assert property (@(posedge clk) disable iff (rst)
        (dqs_rise == {LANES{dqs_rise[0]}} && dqs_fall == {LANES{dqs_fall[0]}}
         && dqs_oe_rise == {LANES{dqs_oe_rise[0]}}
         && dqs_oe_fall == {LANES{dqs_oe_fall[0]}}));

endmodule

bind bser_top bser_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .rd_cmd        (rd_cmd),
    .rd_ready      (rd_ready),
    .dq_rise       (dq_rise),
    .dq_fall       (dq_fall),
    .dq_valid_rise (dq_valid_rise),
    .dq_valid_fall (dq_valid_fall),
    .dqs_rise      (dqs_rise),
    .dqs_fall      (dqs_fall),
    .dqs_oe_rise   (dqs_oe_rise),
    .dqs_oe_fall   (dqs_oe_fall),
    .wr_ready      (wr_ready),
    .wr_word_valid (wr_word_valid)
);

// File: tb/bser_top_tb.sv
`timescale 1ns/1ps
module bser_top_tb_top;
    localparam int LANES = 2;
    localparam int LANE_W = 8;
    localparam int BW = LANES * LANE_W;
    localparam int WW = 4 * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_cmd = 1'b0, rd_bl8 = 1'b0, rd_ilv = 1'b0;
    logic [1:0]    rd_col = 2'd0;
    logic [WW-1:0] rd_word = '0;
    logic          rd_ready;
    logic [BW-1:0] dq_rise, dq_fall;
    logic          dq_valid_rise, dq_valid_fall;
    logic [LANES-1:0] dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall;
    logic          wr_cmd = 1'b0, wr_bl8 = 1'b0, wr_ilv = 1'b0, wr_pair_valid = 1'b0;
    logic [2:0]    wr_col = 3'd0;
    logic [BW-1:0] wr_rise = '0, wr_fall = '0;
    logic          wr_ready;
    logic [WW-1:0] wr_word;
    logic          wr_word_valid, wr_word_sel;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bser_top #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst(rst),
        .rd_cmd(rd_cmd), .rd_bl8(rd_bl8), .rd_col(rd_col), .rd_ilv(rd_ilv),
        .rd_word(rd_word), .rd_ready(rd_ready),
        .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dq_valid_rise(dq_valid_rise), .dq_valid_fall(dq_valid_fall),
        .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
        .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall),
        .wr_cmd(wr_cmd), .wr_bl8(wr_bl8), .wr_col(wr_col), .wr_ilv(wr_ilv),
        .wr_pair_valid(wr_pair_valid), .wr_rise(wr_rise), .wr_fall(wr_fall),
        .wr_ready(wr_ready), .wr_word(wr_word), .wr_word_valid(wr_word_valid),
        .wr_word_sel(wr_word_sel)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot(input int k, input int c, input bit ilv);
        return ilv ? (k ^ c) : ((k + c) % 4);
    endfunction

    function automatic logic [BW-1:0] beat_of(input logic [WW-1:0] w, input int s);
        return w[s*BW +: BW];
    endfunction

    function automatic logic [WW-1:0] mkword(input logic [BW-1:0] base);
        return {base + BW'(3), base + BW'(2), base + BW'(1), base};
    endfunction

    function automatic logic [BW-1:0] wbeat(input int seed, input int k);
        return BW'(16'hA000 + seed * 16 + k);
    endfunction

    // One read data clock: pair index p within the burst, word w.
    task automatic chk_rd_pair(input logic [WW-1:0] w, input int p,
                               input int c, input bit ilv, input string tag);
        logic [BW-1:0] er, ef;
        er = beat_of(w, slot(2 * (p % 2), c, ilv));
        ef = beat_of(w, slot(2 * (p % 2) + 1, c, ilv));
        chk(dq_rise == er, {tag, " R4 rise beat"}, WW'(dq_rise), WW'(er));
        chk(dq_fall == ef, {tag, " R4 fall beat"}, WW'(dq_fall), WW'(ef));
        chk(dq_valid_rise && dq_valid_fall, {tag, " R3 data clock valid"},
            WW'({dq_valid_rise, dq_valid_fall}), WW'(2'b11));
        chk(dqs_rise == '1 && dqs_fall == '0 && dqs_oe_rise == '1 && dqs_oe_fall == '1,
            {tag, " R5/R12 strobe in data"},
            WW'({dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall}), WW'(8'b11001111));
    endtask

    task automatic chk_post_idle(input string tag);
        chk(dqs_oe_rise == '1 && dqs_oe_fall == '0 && dqs_rise == '0 && !dq_valid_rise
            && dq_rise == '0 && dq_fall == '0, {tag, " R6 postamble"},
            WW'({dqs_oe_rise, dqs_oe_fall, dqs_rise, dq_valid_rise}), WW'(7'b1100000));
        @(negedge clk);
        chk(dqs_oe_rise == '0 && dqs_oe_fall == '0 && !dq_valid_rise && rd_ready,
            {tag, " R6 idle after postamble"},
            WW'({dqs_oe_rise, dqs_oe_fall, dq_valid_rise, rd_ready}), WW'(6'b000001));
    endtask

    task automatic rd_burst(input bit bl8, input int c, input bit ilv,
                            input logic [WW-1:0] w0, input logic [WW-1:0] w1);
        int np;
        np = bl8 ? 4 : 2;
        rd_cmd = 1'b1; rd_bl8 = bl8; rd_col = 2'(c); rd_ilv = ilv; rd_word = w0;
        @(negedge clk);
        rd_cmd = 1'b0; rd_word = w1;
        chk(dqs_oe_rise == '1 && dqs_oe_fall == '1 && dqs_rise == '0 && dqs_fall == '0
            && !dq_valid_rise && !dq_valid_fall, "R2 preamble",
            WW'({dqs_oe_rise, dqs_oe_fall, dqs_rise, dqs_fall, dq_valid_rise}),
            WW'(9'b111100000));
        chk(!rd_ready, "R7 not ready in preamble", WW'(rd_ready), WW'(0));
        @(negedge clk);
        rd_word = '0;
        for (int p = 0; p < np; p++) begin
            chk_rd_pair((p >= 2) ? w1 : w0, p, c, ilv, "sweep");
            chk(rd_ready == (bl8 && p == 1), "R7 ready in data",
                WW'(rd_ready), WW'(bl8 && p == 1));
            @(negedge clk);
        end
        chk_post_idle("sweep");
    endtask

    task automatic wr_burst(input bit bl8, input int c, input bit ilv, input int seed);
        int np;
        logic [WW-1:0] ew;
        np = bl8 ? 4 : 2;
        wr_cmd = 1'b1; wr_bl8 = bl8; wr_col = 3'(c); wr_ilv = ilv; wr_pair_valid = 1'b0;
        @(negedge clk);
        wr_cmd = 1'b0;
        for (int p = 0; p < np; p++) begin
            chk(wr_ready == (bl8 && p == 2), "R10 write ready",
                WW'(wr_ready), WW'(bl8 && p == 2));
            wr_pair_valid = 1'b1;
            wr_rise = wbeat(seed, 2 * p);
            wr_fall = wbeat(seed, 2 * p + 1);
            @(negedge clk);
            if (p % 2 == 1) begin
                ew = '0;
                for (int j = 0; j < 4; j++)
                    ew[slot(j, c % 4, ilv)*BW +: BW] = wbeat(seed, (p / 2) * 4 + j);
                chk(wr_word_valid, "R9 word valid", WW'(wr_word_valid), WW'(1));
                chk(wr_word == ew, "R9 word content", wr_word, ew);
                chk(wr_word_sel == (((c >> 2) & 1) ^ (bl8 ? (p / 2) : 0)), "R9 word select",
                    WW'(wr_word_sel), WW'(((c >> 2) & 1) ^ (bl8 ? (p / 2) : 0)));
            end else begin
                chk(!wr_word_valid, "R9 no word mid group", WW'(wr_word_valid), WW'(0));
            end
        end
        wr_pair_valid = 1'b0;
        @(negedge clk);
        chk(!wr_word_valid && wr_ready, "R9 pulse ends, burst closed",
            WW'({wr_word_valid, wr_ready}), WW'(2'b01));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] a0, b1, c0, c1, ew;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!dq_valid_rise && !dq_valid_fall && dqs_oe_rise == '0 && dqs_oe_fall == '0
            && rd_ready && wr_ready && !wr_word_valid, "R1 reset state",
            WW'({dq_valid_rise, dqs_oe_rise, dqs_oe_fall, rd_ready, wr_ready, wr_word_valid}),
            WW'(8'b00000110));

        // R11: pairs with no open write burst
        for (int i = 0; i < 3; i++) begin
            wr_pair_valid = 1'b1; wr_rise = BW'(16'h5500 + i); wr_fall = BW'(16'h6600 + i);
            @(negedge clk);
            chk(!wr_word_valid, "R11 idle pair discarded", WW'(wr_word_valid), WW'(0));
        end
        wr_pair_valid = 1'b0;
        @(negedge clk);
        chk(!wr_word_valid, "R11 idle pair discarded", WW'(wr_word_valid), WW'(0));

        // Read sweep over burst length, order and offset
        for (int b = 0; b < 2; b++)
            for (int il = 0; il < 2; il++)
                for (int c = 0; c < 4; c++)
                    rd_burst(b[0], c, il[0], mkword(BW'(16'h1000 + (b*8+il*4+c)*16)),
                             mkword(BW'(16'h2000 + (b*8+il*4+c)*16)));

        // Read interrupt (R7 hold-off, R8 seamless)
        a0 = mkword(16'h3100); b1 = mkword(16'h3200);
        c0 = mkword(16'h3300); c1 = mkword(16'h3400);
        rd_cmd = 1'b1; rd_bl8 = 1'b1; rd_col = 2'd1; rd_ilv = 1'b0; rd_word = a0;
        @(negedge clk);
        rd_cmd = 1'b1; rd_bl8 = 1'b0; rd_col = 2'd2; rd_ilv = 1'b1; rd_word = b1;
        @(negedge clk);
        rd_cmd = 1'b0; rd_word = '0;
        chk_rd_pair(a0, 0, 1, 1'b0, "R7 held-off command");
        @(negedge clk);
        chk_rd_pair(a0, 1, 1, 1'b0, "R8 before interrupt");
        chk(rd_ready, "R7 ready at interrupt point", WW'(rd_ready), WW'(1));
        rd_cmd = 1'b1; rd_bl8 = 1'b1; rd_col = 2'd2; rd_ilv = 1'b1; rd_word = c0;
        @(negedge clk);
        rd_cmd = 1'b0; rd_word = c1;
        chk_rd_pair(c0, 0, 2, 1'b1, "R8 new burst no preamble");
        @(negedge clk);
        rd_word = '0;
        chk_rd_pair(c0, 1, 2, 1'b1, "R8 new burst");
        @(negedge clk);
        chk_rd_pair(c1, 2, 2, 1'b1, "R8 new second word");
        @(negedge clk);
        chk_rd_pair(c1, 3, 2, 1'b1, "R8 new second word");
        @(negedge clk);
        chk_post_idle("R8");

        // Write sweep
        for (int b = 0; b < 2; b++)
            for (int il = 0; il < 2; il++)
                for (int c = 0; c < 8; c++)
                    wr_burst(b[0], c, il[0], b*16 + il*8 + c);

        // Write interrupt (R10) and accept-cycle discard (R11)
        wr_cmd = 1'b1; wr_bl8 = 1'b1; wr_col = 3'd0; wr_ilv = 1'b0;
        @(negedge clk);
        chk(!wr_ready, "R10 not ready in first group", WW'(wr_ready), WW'(0));
        wr_cmd = 1'b1; wr_bl8 = 1'b0; wr_col = 3'd7; wr_ilv = 1'b1;
        wr_pair_valid = 1'b1; wr_rise = wbeat(40, 0); wr_fall = wbeat(40, 1);
        @(negedge clk);
        wr_cmd = 1'b0;
        wr_rise = wbeat(40, 2); wr_fall = wbeat(40, 3);
        @(negedge clk);
        ew = '0;
        for (int j = 0; j < 4; j++) ew[slot(j, 0, 1'b0)*BW +: BW] = wbeat(40, j);
        chk(wr_word_valid && wr_word == ew && !wr_word_sel, "R10 held-off write command",
            wr_word, ew);
        chk(wr_ready, "R10 ready after first group", WW'(wr_ready), WW'(1));
        wr_cmd = 1'b1; wr_bl8 = 1'b0; wr_col = 3'd5; wr_ilv = 1'b1;
        wr_rise = 16'hDEAD; wr_fall = 16'hBEEF;
        @(negedge clk);
        wr_cmd = 1'b0;
        chk(!wr_word_valid, "R11 accept-cycle pair", WW'(wr_word_valid), WW'(0));
        wr_rise = wbeat(41, 0); wr_fall = wbeat(41, 1);
        @(negedge clk);
        chk(!wr_word_valid, "R10 new burst mid group", WW'(wr_word_valid), WW'(0));
        wr_rise = wbeat(41, 2); wr_fall = wbeat(41, 3);
        @(negedge clk);
        wr_pair_valid = 1'b0;
        ew = '0;
        for (int j = 0; j < 4; j++) ew[slot(j, 1, 1'b1)*BW +: BW] = wbeat(41, j);
        chk(wr_word_valid && wr_word == ew, "R10 interrupting burst word", wr_word, ew);
        chk(wr_word_sel, "R9 select from col bit 2", WW'(wr_word_sel), WW'(1));
        @(negedge clk);
        chk(!wr_word_valid && wr_ready, "R10 old remainder dropped",
            WW'({wr_word_valid, wr_ready}), WW'(2'b01));
        wr_pair_valid = 1'b1; wr_rise = wbeat(42, 0); wr_fall = wbeat(42, 1);
        @(negedge clk);
        wr_rise = wbeat(42, 2); wr_fall = wbeat(42, 3);
        @(negedge clk);
        wr_pair_valid = 1'b0;
        chk(!wr_word_valid, "R11 pairs after close discarded", WW'(wr_word_valid), WW'(0));
        @(negedge clk);
        chk(!wr_word_valid, "R11 pairs after close discarded", WW'(wr_word_valid), WW'(0));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule